// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 32K words by 8 bits. It takes one single-word read or write request at a time and turns it into the chip-enable, write-enable and output-enable waveforms that the memory needs. It drives the memory address, and it uses a split data path (outgoing data, incoming data and a drive-enable for the tristate pad cells). All memory strobes are active low and come straight from flip-flops.

The requester raises `reqValid` with the address, the write flag and the write data, and keeps it high until `ack` pulses. The request is latched when it is accepted, so the request inputs may change after that. Reads capture the memory data at the end of a parameterised access window. Writes hold write enable low for a parameterised number of cycles. The memory latches the data on the rising edge of write enable, and address and data are held for one more cycle after that edge. The controller also inserts an extra quiet cycle before a write that follows a read, so that the pad driver never fights the memory's output drivers.

Top module: `asram_ctrl`

## Requirements
- R1: While synchronous reset is applied and in the first cycle after it, `memCeN`, `memWeN` and `memOeN` are 1, and `memDoutEn` and `ack` are 0.
- R2: In the cycle after `ack`, `memCeN` is 1 and `memDoutEn` is 0. There is always at least one standby cycle between two accesses.
- R3: A read holds `memCeN` low for `ADDR_ACC_CYC` cycles before the data is captured. `memOeN` is low for the last `OE_ACC_CYC` of those cycles and `memWeN` stays high. `rdData` presents the word stored at the requested address while `ack` is high.
- R4: A write holds `memCeN` low for at least one cycle before `memWeN` falls. It then holds `memWeN` low for exactly `WE_PULSE_CYC` cycles. `memDoutEn` is high through the rising edge of `memWeN`, and address and data stay unchanged in the cycle after that edge.
- R5: `memDoutEn` only goes high when `memOeN` was already high in the previous cycle. It is never high while `memOeN` is low.
- R6: A write that directly follows a read takes exactly one cycle more from acceptance to `ack` than a write that follows a write or reset.
- R7: `ack` is a one-cycle pulse. Counting the negedges after `reqValid` is presented in a standby cycle, `ack` is first seen on negedge `ADDR_ACC_CYC + 1` for a read. For a write it is first seen on negedge `WR_SETUP + WE_PULSE_CYC + 1`, plus one more after a read. Here `WR_SETUP` = max(1, `ADDR_ACC_CYC - WE_PULSE_CYC - 1`).
- R8: Address, write data and the write flag are taken only when a request is accepted in standby. Changing them during an access has no effect on that access. `memAddr` stays stable while `memCeN` stays low.
- R9: Every access, read or write, keeps `memCeN` low for at least `ADDR_ACC_CYC` consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present; held until `ack` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Data to write |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Captured read data |
| memAddr | output | ADDR_W | Memory address pins |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDout | output | DATA_W | Data toward the pads |
| memDoutEn | output | 1 | Pad drive-enable, active high |
| memDin | input | DATA_W | Data from the pads |

## Verification
The bench builds the controller with `ADDR_ACC_CYC` = 5, `OE_ACC_CYC` = 2 and `WE_PULSE_CYC` = 2. With these values the read setup phase lasts three cycles and the write setup phase is stretched to two cycles to meet the cycle time, so every wait counter runs more than one step. The bench's memory model returns valid data only once chip enable and output enable have each been low for their required number of cycles. An early capture therefore shows up as wrong data. Writes land in the model only on a write-enable rising edge, at the address present on that edge.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACCESS = 3'd2,
    ST_HOLD   = 3'd3,
    ST_TURN   = 3'd4
  } ctlState_e;

  // Control-to-datapath strobes. loadReq and capture act at the coming
  // edge; the *On fields are the pin levels for the coming cycle.
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic ceOn;
    logic weOn;
    logic oeOn;
    logic driveOn;
    logic ackOn;
  } strobe_t;

endpackage

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_ACC_CYC = 4,
  parameter int OE_ACC_CYC   = 2,
  parameter int WE_PULSE_CYC = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t strb
);

  localparam int RD_SETUP_CYC = ADDR_ACC_CYC - OE_ACC_CYC;
  localparam int WR_SETUP_CYC = (ADDR_ACC_CYC > WE_PULSE_CYC + 1) ?
                                (ADDR_ACC_CYC - WE_PULSE_CYC - 1) : 1;
  localparam int MAX_A   = (RD_SETUP_CYC > WR_SETUP_CYC) ? RD_SETUP_CYC : WR_SETUP_CYC;
  localparam int MAX_B   = (OE_ACC_CYC > WE_PULSE_CYC) ? OE_ACC_CYC : WE_PULSE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RD_SETUP_LD = CNT_W'(RD_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WR_SETUP_LD = CNT_W'(WR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] OE_LD       = CNT_W'(OE_ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD       = CNT_W'(WE_PULSE_CYC - 1);

  ctlState_e        state, stateNext;
  logic [CNT_W-1:0] waitCnt, cntNext;
  logic             isWrite, isWriteNext;
  logic             lastRead, lastReadNext;
  logic             loadReq, capture;

  always_comb begin
    stateNext    = state;
    cntNext      = waitCnt;
    loadReq      = 1'b0;
    capture      = 1'b0;
    lastReadNext = lastRead;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          loadReq = 1'b1;
          if (reqWrite && lastRead) begin
            stateNext = ST_TURN;
          end else begin
            stateNext = ST_SETUP;
            cntNext   = reqWrite ? WR_SETUP_LD : RD_SETUP_LD;
          end
        end
      end
      ST_TURN: begin
        stateNext = ST_SETUP;
        cntNext   = WR_SETUP_LD;
      end
      ST_SETUP: begin
        if (waitCnt == '0) begin
          stateNext = ST_ACCESS;
          cntNext   = isWrite ? WE_LD : OE_LD;
        end else begin
          cntNext = waitCnt - 1'b1;
        end
      end
      ST_ACCESS: begin
        if (waitCnt == '0) begin
          stateNext = ST_HOLD;
          capture   = ~isWrite;
        end else begin
          cntNext = waitCnt - 1'b1;
        end
      end
      ST_HOLD: begin
        stateNext    = ST_IDLE;
        lastReadNext = ~isWrite;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign isWriteNext = loadReq ? reqWrite : isWrite;

  // Pin levels decoded from the next state so the datapath flops them
  // without adding a cycle of lag.
  always_comb begin
    strb.loadReq = loadReq;
    strb.capture = capture;
    strb.ceOn    = (stateNext == ST_SETUP) || (stateNext == ST_ACCESS) ||
                   (stateNext == ST_HOLD);
    strb.weOn    = (stateNext == ST_ACCESS) && isWriteNext;
    strb.oeOn    = (stateNext == ST_ACCESS) && !isWriteNext;
    strb.driveOn = isWriteNext && ((stateNext == ST_ACCESS) || (stateNext == ST_HOLD));
    strb.ackOn   = (stateNext == ST_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      isWrite  <= 1'b0;
      lastRead <= 1'b0;
    end else begin
      state    <= stateNext;
      waitCnt  <= cntNext;
      isWrite  <= isWriteNext;
      lastRead <= lastReadNext;
    end
  end

  // R6: the quiet cycle is entered only for a write that follows a read
  assert_turn_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN) |-> (isWrite && lastRead));

  // R4: the strobe phase is always preceded by the setup phase
  assert_setup_first_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACCESS && $past(state) != ST_ACCESS) |-> ($past(state) == ST_SETUP));

  // R8: the request is held only while no access is running
  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> !(strb.loadReq && state != ST_IDLE));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] rdData,
  output logic              ack
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.loadReq) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.capture) begin
      rdData <= memDin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memCeN    <= 1'b1;
      memWeN    <= 1'b1;
      memOeN    <= 1'b1;
      memDoutEn <= 1'b0;
      ack       <= 1'b0;
    end else begin
      memCeN    <= ~strb.ceOn;
      memWeN    <= ~strb.weOn;
      memOeN    <= ~strb.oeOn;
      memDoutEn <= strb.driveOn;
      ack       <= strb.ackOn;
    end
  end

  assign memAddr = addrQ;
  assign memDout = dataQ;

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_standby_after_ack_R2: assert property (@(posedge clk) disable iff (rst)
    ack |=> (memCeN && !memDoutEn));

  assert_drive_after_oe_R5: assert property (@(posedge clk) disable iff (rst)
    (memDoutEn && !$past(memDoutEn)) |-> ($past(memOeN) && memOeN));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> memOeN);

  assert_we_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> !$past(memCeN));

  assert_we_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (!memCeN && memDoutEn && $stable(memAddr) && $stable(memDout)));

  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (!memCeN && memWeN));

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int ADDR_ACC_CYC = 4,
  parameter int OE_ACC_CYC   = 2,
  parameter int WE_PULSE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  strobe_t strb;

  asram_ctl #(
    .ADDR_ACC_CYC(ADDR_ACC_CYC),
    .OE_ACC_CYC  (OE_ACC_CYC),
    .WE_PULSE_CYC(WE_PULSE_CYC)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strb    (strb)
  );

  asram_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .rdData   (rdData),
    .ack      (ack)
  );

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int A  = 5;
  localparam int O  = 2;
  localparam int W  = 2;
  localparam int WS = (A > W + 1) ? (A - W - 1) : 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ack;
  logic [7:0]  rdData;
  logic [14:0] memAddr;
  logic        memCeN, memWeN, memOeN, memDoutEn;
  logic [7:0]  memDout;
  logic [7:0]  memDin;

  int checks = 0;
  int fails  = 0;

  logic [7:0] modelMem [int];
  logic [7:0] expMem   [int];
  int mCe = 0;
  int mOe = 0;

  always #10 clk = ~clk;

  asram_ctrl #(
    .ADDR_ACC_CYC(A),
    .OE_ACC_CYC  (O),
    .WE_PULSE_CYC(W)
  ) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ack(ack), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  function automatic logic [7:0] modelRead(input logic [14:0] a);
    if (modelMem.exists(int'(a))) return modelMem[int'(a)];
    return 8'h00;
  endfunction

  function automatic logic [7:0] expRead(input logic [14:0] a);
    if (expMem.exists(int'(a))) return expMem[int'(a)];
    return 8'h00;
  endfunction

  function automatic int expLatency(input bit wr, input bit afterRead);
    if (!wr) return A + 1;
    return WS + W + 1 + (afterRead ? 1 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model: data valid only after the access and output-enable times
  always @(posedge clk) begin
    mCe <= memCeN ? 0 : mCe + 1;
    mOe <= memOeN ? 0 : mOe + 1;
  end
  assign memDin = (!memCeN && !memOeN && memWeN && mCe >= A - 1 && mOe >= O - 1) ?
                  modelRead(memAddr) : 8'hC3;

  // Strobe monitor
  logic        pCeN = 1'b1, pWeN = 1'b1, pOeN = 1'b1, pEn = 1'b0;
  logic [14:0] pAddr = '0;
  logic [7:0]  pDout = '0;
  int ceRun = 0, oeRun = 0, weRun = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (memCeN && !pCeN) chk(ceRun >= A, "R9", "chip enable low run", ceRun, A);
      if (memOeN && !pOeN) chk(oeRun == O, "R3", "output enable low run", oeRun, O);
      if (!memWeN && pWeN) chk(!pCeN, "R4", "chip enable before write strobe", pCeN, 0);
      if (memWeN && !pWeN) begin
        chk(weRun == W, "R4", "write strobe width", weRun, W);
        chk(memDoutEn && !memCeN, "R4", "drive through write edge", memDoutEn, 1);
        chk(memAddr == pAddr && memDout == pDout, "R4", "hold after write edge",
            memAddr, pAddr);
        modelMem[int'(pAddr)] = pDout;
      end
      if (!memCeN && !pCeN) chk(memAddr == pAddr, "R8", "address stable", memAddr, pAddr);
      if (memDoutEn && !pEn) chk(pOeN && memOeN, "R5", "drive after output disable", pOeN, 1);
      if (memDoutEn) chk(memOeN, "R5", "no contention", memOeN, 1);
      if (!memOeN) chk(!memCeN && memWeN, "R3", "read strobes", memWeN, 1);
      ceRun = memCeN ? 0 : ceRun + 1;
      oeRun = memOeN ? 0 : oeRun + 1;
      weRun = memWeN ? 0 : weRun + 1;
    end
    pCeN = memCeN; pWeN = memWeN; pOeN = memOeN; pEn = memDoutEn;
    pAddr = memAddr; pDout = memDout;
  end

  bit lastWasRead = 1'b0;

  task automatic doAccess(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int cnt = 0;
    int lat = expLatency(wr, lastWasRead);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (1) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        reqAddr  = ~a;      // R8: changes after acceptance must be ignored
        reqWdata = ~d;
        reqWrite = ~wr;
      end
      if (ack || cnt > 40) break;
    end
    chk(cnt == lat, lastWasRead && wr ? "R6" : "R7", "ack latency", cnt, lat);
    if (!wr) chk(rdData == expRead(a), "R3", "read data", rdData, expRead(a));
    else expMem[int'(a)] = d;
    reqValid = 1'b0;
    @(negedge clk);
    chk(!ack, "R7", "ack single pulse", ack, 0);
    chk(memCeN && !memDoutEn, "R2", "standby after ack", memCeN, 1);
    lastWasRead = !wr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(memCeN && memWeN && memOeN && !memDoutEn && !ack, "R1", "pins in reset",
        {memCeN, memWeN, memOeN, memDoutEn, ack}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(memCeN && memWeN && memOeN && !memDoutEn && !ack, "R1", "pins after reset",
        {memCeN, memWeN, memOeN, memDoutEn, ack}, 5'b11100);

    // Directed corners
    doAccess(1'b1, 15'h0000, 8'h11);      // write after reset
    doAccess(1'b1, 15'h7FFF, 8'hEE);      // write after write
    doAccess(1'b0, 15'h7FFF, 8'h00);      // R3 top address
    doAccess(1'b0, 15'h0000, 8'h00);      // read after read
    doAccess(1'b1, 15'h0000, 8'h5A);      // R6 write after read
    doAccess(1'b0, 15'h0000, 8'h00);
    doAccess(1'b0, 15'h1234, 8'h00);      // never written
    doAccess(1'b1, 15'h4001, 8'hA5);
    doAccess(1'b0, 15'h4001, 8'h00);

    // Random mix over a small address pool
    for (int i = 0; i < 80; i++) begin
      logic [14:0] a;
      a = 15'($urandom) & 15'h700F;
      doAccess(1'($urandom), a, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule